// File: doc/BRIEF.md
# Dual-Clock FIFO with 33 Entries

This block is a first-in first-out buffer between two unrelated clock domains. It holds exactly 33 words, a count that is not a power of two, so a power-of-two array is not needed just to get a ready-made pointer scheme. A producer in the write domain pushes words with a write enable and watches a full flag. A consumer in the read domain sees the oldest unread word on its data output whenever the empty flag is low, and pops it with a read enable.

Each side keeps two counters. A physical index from 0 to 32 addresses the storage array and wraps to 0 after 32. A free-running logical count of six bits is used only for the occupancy flags. The logical count is turned into Gray code in a register and crosses into the other domain through a two-stage synchronizer. There it is turned back into binary and compared. Empty is an equality test on the logical counts. Full compares the write count with the synchronized read count plus 33, modulo 64. Both flags are pessimistic by the synchronizer delay and are never optimistic.

Top module: `odd_depth_afifo`

## Requirements
- R1: Each domain has its own synchronous active-high reset. Directly after reset, rd_empty is 1 and wr_full is 0.
- R2: While rd_empty is 0, rd_data shows the oldest unread word. A read-clock edge with rd_en=1 and rd_empty=0 removes that word and presents the next one. Words leave in the order they were written.
- R3: A write attempted while wr_full is 1 is dropped. The storage and the write pointers stay unchanged, and the 33 words already held are read out intact afterwards.
- R4: rd_empty rises right after the read edge that removes the last visible word. After a write accepted at a write edge, rd_empty falls after the second read-clock rising edge that follows it (two synchronizer stages).
- R5: wr_full rises right after the write edge that stores the 33rd unread word. After a read at a read edge, wr_full falls after the second write-clock rising edge that follows it.
- R6: Starting from empty, with no reads, exactly 33 writes are accepted before wr_full rises.
- R7: A read attempted while rd_empty is 1 is ignored. The read pointers stay unchanged, and later data comes out correctly.
- R8: The physical indexes count 0..32 and wrap from 32 to 0. The 6-bit logical counts wrap modulo 64. Data order and both flags stay exact over many laps of both counters.
- R9: Each logical count crosses domains in Gray code and changes at most one bit per clock. The flags stay exact under sustained traffic at the full boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst | input | 1 | Write-domain synchronous reset, active high |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| wr_full | output | 1 | No free entry seen by the write side |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst | input | 1 | Read-domain synchronous reset, active high |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Oldest unread word (valid while rd_empty is 0) |
| rd_empty | output | 1 | No unread word seen by the read side |

## Verification
Every state fault in this block reaches the ports quickly. A physical index that wraps at the wrong value puts a wrong or stale word on rd_data within one lap of 33 words. A wrong logical count or a bad full offset moves a flag edge by at least one cycle. The bench catches that on the very cycle the flag is expected to change, because the reference model predicts each flag edge to the exact clock, including the two-edge synchronizer delay. A dropped write or a read while empty that wrongly advances a pointer shifts the data sequence at once, and the first affected word is flagged on the cycle it is presented.

// File: rtl/ofifo_pkg.sv
`timescale 1ns/1ps
package ofifo_pkg;

    localparam int unsigned FIFO_DEPTH_DEF  = 33;
    localparam int unsigned SYNC_STAGES_DEF = 2;
    localparam int unsigned CODE_W          = 16;

    typedef logic [CODE_W-1:0] code_t;

    // Reflected binary code of a count.
    function automatic code_t bin_to_gray(code_t b);
        return b ^ (b >> 1);
    endfunction

    // Prefix XOR from the top bit down.
    function automatic code_t gray_to_bin(code_t g);
        code_t b;
        b[CODE_W-1] = g[CODE_W-1];
        for (int i = CODE_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    // Width of a logical count that separates 0..depth.
    function automatic int unsigned logical_width(int unsigned depth);
        return $clog2(depth + 1);
    endfunction

    // Width of a physical index covering 0..depth-1.
    function automatic int unsigned index_width(int unsigned depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

endpackage

// File: rtl/ofifo_sync.sv
`timescale 1ns/1ps
module ofifo_sync #(
    parameter int unsigned W      = 6,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage[s] <= '0;
                else     stage[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage[s] <= '0;
                else     stage[s] <= stage[s-1];
            end
        end
    end

    assign q = stage[STAGES-1];

endmodule

// File: rtl/ofifo_ptr.sv
`timescale 1ns/1ps
module ofifo_ptr #(
    parameter int unsigned DEPTH = 33,
    parameter int unsigned AW    = 6,
    parameter int unsigned LW    = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    output logic [AW-1:0] phys,
    output logic [LW-1:0] bin,
    output logic [LW-1:0] gray
);

    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    logic [AW-1:0] phys_nx;
    logic [LW-1:0] bin_nx;

    always_comb begin
        bin_nx  = bin + 1'b1;
        phys_nx = (phys == LAST_IDX) ? '0 : phys + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phys <= '0;
            bin  <= '0;
            gray <= '0;
        end else if (adv) begin
            phys <= phys_nx;
            bin  <= bin_nx;
            gray <= LW'(ofifo_pkg::bin_to_gray(ofifo_pkg::code_t'(bin_nx)));
        end
    end

endmodule

// File: rtl/ofifo_mem.sv
`timescale 1ns/1ps
module ofifo_mem #(
    parameter int unsigned DEPTH  = 33,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned AW     = 6
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/odd_depth_afifo.sv
`timescale 1ns/1ps
module odd_depth_afifo #(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned DEPTH       = ofifo_pkg::FIFO_DEPTH_DEF,
    parameter int unsigned SYNC_STAGES = ofifo_pkg::SYNC_STAGES_DEF
) (
    input  logic              wr_clk,
    input  logic              wr_rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_full,
    input  logic              rd_clk,
    input  logic              rd_rst,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_empty
);

    localparam int unsigned   AW       = ofifo_pkg::index_width(DEPTH);
    localparam int unsigned   LW       = ofifo_pkg::logical_width(DEPTH);
    localparam logic [LW-1:0] FULL_GAP = LW'(DEPTH);

    logic          wr_push, rd_pop;
    logic [AW-1:0] wr_phys, rd_phys;
    logic [LW-1:0] wr_bin, wr_gray, rd_bin, rd_gray;
    logic [LW-1:0] wr_gray_in_rd, rd_gray_in_wr;
    logic [LW-1:0] wr_bin_in_rd, rd_bin_in_wr;

    assign wr_push = wr_en & ~wr_full;
    assign rd_pop  = rd_en & ~rd_empty;

    ofifo_ptr #(.DEPTH(DEPTH), .AW(AW), .LW(LW)) u_wptr (
        .clk (wr_clk), .rst (wr_rst), .adv (wr_push),
        .phys(wr_phys), .bin (wr_bin), .gray(wr_gray)
    );

    ofifo_ptr #(.DEPTH(DEPTH), .AW(AW), .LW(LW)) u_rptr (
        .clk (rd_clk), .rst (rd_rst), .adv (rd_pop),
        .phys(rd_phys), .bin (rd_bin), .gray(rd_gray)
    );

    ofifo_sync #(.W(LW), .STAGES(SYNC_STAGES)) u_w2r (
        .clk(rd_clk), .rst(rd_rst), .d(wr_gray), .q(wr_gray_in_rd)
    );

    ofifo_sync #(.W(LW), .STAGES(SYNC_STAGES)) u_r2w (
        .clk(wr_clk), .rst(wr_rst), .d(rd_gray), .q(rd_gray_in_wr)
    );

    always_comb begin
        wr_bin_in_rd = LW'(ofifo_pkg::gray_to_bin(ofifo_pkg::code_t'(wr_gray_in_rd)));
        rd_bin_in_wr = LW'(ofifo_pkg::gray_to_bin(ofifo_pkg::code_t'(rd_gray_in_wr)));
    end

    // Full: write count runs DEPTH ahead of the seen read count, modulo 2**LW.
    assign wr_full  = (wr_bin == LW'(rd_bin_in_wr + FULL_GAP));
    assign rd_empty = (rd_bin == wr_bin_in_rd);

    ofifo_mem #(.DEPTH(DEPTH), .DATA_W(DATA_W), .AW(AW)) u_mem (
        .wclk (wr_clk),
        .we   (wr_push),
        .waddr(wr_phys),
        .wdata(wr_data),
        .raddr(rd_phys),
        .rdata(rd_data)
    );

endmodule

// File: rtl/ofifo_checker.sv
`timescale 1ns/1ps
module ofifo_checker #(
    parameter int unsigned DEPTH = 33,
    parameter int unsigned AW    = 6,
    parameter int unsigned LW    = 6
) (
    input logic          wr_clk,
    input logic          wr_rst,
    input logic          wr_en,
    input logic          wr_full,
    input logic [AW-1:0] wr_phys,
    input logic [LW-1:0] wr_gray,
    input logic          rd_clk,
    input logic          rd_rst,
    input logic          rd_en,
    input logic          rd_empty,
    input logic [AW-1:0] rd_phys,
    input logic [LW-1:0] rd_gray
);

    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    AST_RESET_EMPTY: assert property (@(posedge rd_clk) disable iff (rd_rst)
        $fell(rd_rst) |-> rd_empty); // R1
    AST_RESET_NOT_FULL: assert property (@(posedge wr_clk) disable iff (wr_rst)
        $fell(wr_rst) |-> !wr_full); // R1
    AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (wr_en && wr_full) |=> ($stable(wr_phys) && $stable(wr_gray))); // R3
    AST_NO_UNDERFLOW: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (rd_en && rd_empty) |=> ($stable(rd_phys) && $stable(rd_gray))); // R7
    AST_WR_INDEX_RANGE: assert property (@(posedge wr_clk) disable iff (wr_rst)
        wr_phys <= LAST_IDX); // R8
    AST_RD_INDEX_RANGE: assert property (@(posedge rd_clk) disable iff (rd_rst)
        rd_phys <= LAST_IDX); // R8
    AST_WR_INDEX_WRAP: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (wr_en && !wr_full && wr_phys == LAST_IDX) |=> (wr_phys == '0)); // R8
    AST_RD_INDEX_WRAP: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (rd_en && !rd_empty && rd_phys == LAST_IDX) |=> (rd_phys == '0)); // R8
    AST_WR_GRAY_STEP: assert property (@(posedge wr_clk) disable iff (wr_rst)
        $countones(wr_gray ^ $past(wr_gray)) <= 1); // R9
    AST_RD_GRAY_STEP: assert property (@(posedge rd_clk) disable iff (rd_rst)
        $countones(rd_gray ^ $past(rd_gray)) <= 1); // R9

endmodule

bind odd_depth_afifo ofifo_checker #(.DEPTH(DEPTH), .AW(AW), .LW(LW)) u_chk (
    .wr_clk  (wr_clk),
    .wr_rst  (wr_rst),
    .wr_en   (wr_en),
    .wr_full (wr_full),
    .wr_phys (wr_phys),
    .wr_gray (wr_gray),
    .rd_clk  (rd_clk),
    .rd_rst  (rd_rst),
    .rd_en   (rd_en),
    .rd_empty(rd_empty),
    .rd_phys (rd_phys),
    .rd_gray (rd_gray)
);

// File: tb/test_odd_depth_afifo.sv
`timescale 1ns/1ps
module test_odd_depth_afifo;

    localparam int DW    = 8;
    localparam int DEPTH = 33;
    localparam int END_CYC = 4125;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0, rd_en = 1'b0;
    logic [DW-1:0] din = '0;
    logic          wr_full, rd_empty;
    logic [DW-1:0] rd_data;

    always #10 clk = ~clk;

    // Both domains run from one 50 MHz clock so flag edges are exact.
    odd_depth_afifo #(.DATA_W(DW), .DEPTH(DEPTH), .SYNC_STAGES(2)) i_odd_depth_afifo (
        .wr_clk(clk), .wr_rst(rst), .wr_en(wr_en), .wr_data(din), .wr_full(wr_full),
        .rd_clk(clk), .rd_rst(rst), .rd_en(rd_en), .rd_data(rd_data), .rd_empty(rd_empty)
    );

    // Reference model: counts, synchronizer delays and a queue.
    int unsigned   wtot = 0, rtot = 0, ws1 = 0, ws2 = 0, rs1 = 0, rs2 = 0;
    int unsigned   fill_acc = 0;
    logic [DW-1:0] q [$];
    int            n_chk = 0, n_fail = 0, cyc = 0;
    logic [15:0]   lfsr = 16'hACE1;
    bit            done = 0;

    function automatic bit m_empty();
        return rtot == ws2;
    endfunction

    function automatic bit m_full();
        return (wtot - rs2) == DEPTH;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            wtot = 0; rtot = 0; ws1 = 0; ws2 = 0; rs1 = 0; rs2 = 0;
            q.delete();
        end else begin
            bit acc_w, acc_r;
            acc_w = wr_en && !m_full();
            acc_r = rd_en && !m_empty();
            ws2 = ws1; ws1 = wtot;
            rs2 = rs1; rs1 = rtot;
            if (acc_w) begin
                q.push_back(din);
                wtot++;
                if (cyc >= 5 && cyc < 55) fill_acc++;
            end
            if (acc_r) begin
                void'(q.pop_front());
                rtot++;
            end
        end
    end

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    function automatic string data_tag();
        if (cyc < 55)   return "R3";
        if (cyc < 115)  return "R7";
        if (cyc < 2115) return "R2";
        return "R8";
    endfunction

    always @(negedge clk) begin
        if (!done) begin
            string te, tf;
            // Flag tags: reset phases R1; full-boundary laps R9 (Gray crossing).
            if (rst) begin te = "R1"; tf = "R1"; end
            else if (cyc >= 2115) begin te = "R9"; tf = "R9"; end
            else begin te = "R4"; tf = "R5"; end
            check(te, "rd_empty", int'(rd_empty), int'(m_empty()));
            check(tf, "wr_full",  int'(wr_full),  int'(m_full()));
            if (!rst && !m_empty() && q.size() > 0)
                check(data_tag(), "rd_data", int'(rd_data), int'(q[0]));
            if (cyc == 55) begin
                check("R6", "writes accepted before full", int'(fill_acc), DEPTH);
                check("R6", "wr_full after fill", int'(wr_full), 1);
            end

            cyc++;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            din  = din + 1'b1;
            if (cyc < 5) begin
                rst = 1; wr_en = 0; rd_en = 0;
            end else if (cyc < 55) begin         // fill past capacity (R3, R6)
                rst = 0; wr_en = 1; rd_en = 0;
            end else if (cyc < 115) begin        // drain past empty (R7)
                wr_en = 0; rd_en = 1;
            end else if (cyc < 2115) begin       // balanced mixed traffic (R2, R8)
                wr_en = lfsr[0]; rd_en = lfsr[3];
            end else if (cyc < 4115) begin       // write-heavy, sits at full (R9)
                wr_en = lfsr[0] | lfsr[5]; rd_en = lfsr[1] & lfsr[2];
            end else begin                       // second reset (R1)
                rst = 1; wr_en = 0; rd_en = 0;
            end

            if (cyc == END_CYC) begin
                done = 1;
                $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
                $finish;
            end
        end
    end

    initial begin
        #(20 * 10000);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual cycle %0d expected %0d", cyc, END_CYC);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule